// File: doc/BRIEF.md
# Multiplexed LED Scanner with Gamma-Corrected PWM Dimming

This block scans a time-multiplexed LED display such as a row of seven-segment digits. One digit enable is active at a time. The scanner steps through all digits once per frame, so each digit gets a slot of `TICK_HZ / (FRAME_HZ * NUM_DIGITS)` PWM ticks. During its slot, the digit's segment channels are driven in parallel.

Each segment of each digit has its own brightness. A brightness is a perceived-level number from 0 to `LVL_MAX`. A table computed at elaboration maps it to an on-time in ticks that follows a 2.2 power law. A segment lights while the slot tick counter is below its mapped on-time and its pattern bit is set. Between two slots there is one blank clock: all segments are low and the previous digit enable is still shown. The enable changes on the clock after that.

The pattern and the levels reach the block over a valid/ready handshake. Ready is high for exactly one clock, the blank clock that opens each frame. A transfer happens only when valid and ready are high in the same clock. A producer that has new data holds valid and the data until it sees ready. Data offered at any other time is not taken, and the previous frame's values stay in use.

Top module: `led_mux_pwm`

## Requirements
- R1: While the synchronous reset is high, all digit enables, all segment outputs and `cfg_ready_o` are low, and the stored pattern and levels are cleared to zero. After release, scanning starts at digit 0 with the tick count at 0.
- R2: From the first clock after reset, exactly one bit of `digit_en_o` is high. Digits are visited in index order 0, 1, …, N-1 and then wrap to 0. Each slot consists of `SLOT_TICKS = TICK_HZ/(FRAME_HZ*NUM_DIGITS)` accepted ticks plus one blank clock.
- R3: A clock with `tick_en_i` low does not advance the slot tick counter, so the digit enable and the segment outputs keep their values.
- R4: Segment `s` of digit `d` uses pattern bit `d*NUM_SEGS+s` and level field `[(d*NUM_SEGS+s)*LVL_W +: LVL_W]`. Its output is high only while that digit's slot is running, the pattern bit is 1 and the tick count is below the mapped on-time.
- R5: Level L maps to `round(SLOT_TICKS*(L/LVL_MAX)^2.2)` ticks. Level 0 gives 0 ticks, `LVL_MAX` and any larger code give the full `SLOT_TICKS`, and every nonzero level gives at least 1 tick.
- R6: When a slot ends, all segments are low for one clock while `digit_en_o` still shows the old digit. The new digit enable appears on the following clock.
- R7: `cfg_ready_o` is high only during the blank clock that opens digit 0, and never during reset. Pattern and levels are stored only when `cfg_valid_i` and `cfg_ready_o` are both high. All other offered data is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| tick_en_i | input | 1 | PWM time-base tick enable |
| cfg_valid_i | input | 1 | Frame data offered |
| cfg_ready_o | output | 1 | Frame data accepted this clock if valid |
| cfg_pattern_i | input | NUM_DIGITS*NUM_SEGS | Segment on/off pattern, digit-major |
| cfg_level_i | input | NUM_DIGITS*NUM_SEGS*LVL_W | Perceived brightness levels, same order as the pattern |
| digit_en_o | output | NUM_DIGITS | One-hot digit enables |
| seg_o | output | NUM_SEGS | Segment drives |

## Verification
All outputs are combinational functions of registered state. A change that an edge causes is therefore visible right after that edge. The digit enable is the exception: it lags the internal digit index by one clock, which is the blank clock. Data accepted in the ready clock first affects segments one clock later, at tick 0 of digit 0.

The bench keeps a per-clock reference of the slot count, the digit and the stored frame. It compares every output at the falling edge, after all updates from the preceding rising edge have settled. A directed frame then counts the high clocks of each segment over one digit slot and compares the total with the power-law on-time for that level.

// File: rtl/led_scan_pkg.sv
package led_scan_pkg;

  // Perceived level -> on-time in ticks, power law with exponent 2.2.
  function automatic int gamma_ticks(input int lvl, input int lmax, input int slot);
    real frac;
    real scaled;
    int  v;
    if (lvl <= 0) return 0;
    if (lvl >= lmax) return slot;
    frac   = real'(lvl) / real'(lmax);
    scaled = real'(slot) * $pow(frac, 2.2);
    v      = $rtoi(scaled + 0.5);
    if (v < 1) v = 1;
    return v;
  endfunction

endpackage

// File: rtl/led_gamma_lut.sv
module led_gamma_lut #(
  parameter int LVL_W      = 6,
  parameter int LVL_MAX    = 35,
  parameter int SLOT_TICKS = 2500,
  parameter int CNT_W      = 12
) (
  input  logic [LVL_W-1:0] lvl_i,
  output logic [CNT_W-1:0] on_ticks_o
);
  localparam int ENTRIES = 1 << LVL_W;

  logic [CNT_W-1:0] rom [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_rom
    localparam int LCLAMP = (i > LVL_MAX) ? LVL_MAX : i;
    localparam int ONV    = led_scan_pkg::gamma_ticks(LCLAMP, LVL_MAX, SLOT_TICKS);
    assign rom[i] = CNT_W'(ONV);
  end

  assign on_ticks_o = rom[lvl_i];
endmodule

// File: rtl/led_scan_timer.sv
module led_scan_timer #(
  parameter int NUM_DIGITS = 4,
  parameter int SLOT_TICKS = 2500,
  parameter int CNT_W      = 12,
  parameter int DIG_W      = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_i,
  input  logic                  tick_en_i,
  output logic [CNT_W-1:0]      cnt_o,
  output logic [DIG_W-1:0]      dig_o,
  output logic                  blank_o,
  output logic [NUM_DIGITS-1:0] dig_en_o
);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SLOT_TICKS - 1);
  localparam logic [DIG_W-1:0] DIG_LAST = DIG_W'(NUM_DIGITS - 1);

  logic [CNT_W-1:0]      cnt_q;
  logic [DIG_W-1:0]      dig_q;
  logic                  blank_q;
  logic [NUM_DIGITS-1:0] den_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q   <= '0;
      dig_q   <= '0;
      blank_q <= 1'b1;
      den_q   <= '0;
    end else begin
      den_q <= NUM_DIGITS'(1) << dig_q;   // enable trails the index by one clock
      if (blank_q) begin
        blank_q <= 1'b0;
      end else if (tick_en_i) begin
        if (cnt_q == CNT_LAST) begin
          cnt_q   <= '0;
          blank_q <= 1'b1;
          dig_q   <= (dig_q == DIG_LAST) ? '0 : dig_q + 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign cnt_o    = cnt_q;
  assign dig_o    = dig_q;
  assign blank_o  = blank_q;
  assign dig_en_o = den_q;

  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    (!tick_en_i || blank_q) |=> $stable(cnt_q)); // R3
  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (rst_i)
    cnt_q <= CNT_LAST); // R2
  AST_DIG_ORDER: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(blank_q) |-> (dig_q == (($past(dig_q) == DIG_LAST) ? '0 : $past(dig_q) + 1'b1))); // R2
endmodule

// File: rtl/led_seg_pwm.sv
module led_seg_pwm #(
  parameter int NUM_SEGS   = 8,
  parameter int LVL_W      = 6,
  parameter int LVL_MAX    = 35,
  parameter int SLOT_TICKS = 2500,
  parameter int CNT_W      = 12
) (
  input  logic [CNT_W-1:0]          cnt_i,
  input  logic                      blank_i,
  input  logic [NUM_SEGS-1:0]       pat_i,
  input  logic [NUM_SEGS*LVL_W-1:0] lvl_i,
  output logic [NUM_SEGS-1:0]       seg_o
);
  for (genvar s = 0; s < NUM_SEGS; s++) begin : g_seg
    logic [CNT_W-1:0] on_t;
    led_gamma_lut #(
      .LVL_W(LVL_W), .LVL_MAX(LVL_MAX), .SLOT_TICKS(SLOT_TICKS), .CNT_W(CNT_W)
    ) u_lut (
      .lvl_i      (lvl_i[s*LVL_W +: LVL_W]),
      .on_ticks_o (on_t)
    );
    assign seg_o[s] = ~blank_i & pat_i[s] & (cnt_i < on_t);
  end
endmodule

// File: rtl/led_mux_pwm.sv
module led_mux_pwm #(
  parameter int TICK_HZ    = 1_000_000,
  parameter int FRAME_HZ   = 100,
  parameter int NUM_DIGITS = 4,
  parameter int NUM_SEGS   = 8,
  parameter int LVL_MAX    = 35,
  localparam int LVL_W     = $clog2(LVL_MAX + 1),
  localparam int PAT_W     = NUM_DIGITS * NUM_SEGS,
  localparam int LVLS_W    = PAT_W * LVL_W
) (
  input  logic                  clk_i,
  input  logic                  rst_i,
  input  logic                  tick_en_i,
  input  logic                  cfg_valid_i,
  output logic                  cfg_ready_o,
  input  logic [PAT_W-1:0]      cfg_pattern_i,
  input  logic [LVLS_W-1:0]     cfg_level_i,
  output logic [NUM_DIGITS-1:0] digit_en_o,
  output logic [NUM_SEGS-1:0]   seg_o
);
  localparam int SLOT_TICKS = TICK_HZ / (FRAME_HZ * NUM_DIGITS);
  localparam int CNT_W      = $clog2(SLOT_TICKS + 1);
  localparam int DIG_W      = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1;
  localparam int SLICE_W    = NUM_SEGS * LVL_W;

  logic [CNT_W-1:0]    cnt;
  logic [DIG_W-1:0]    dig;
  logic                blank;
  logic [PAT_W-1:0]    pat_q;
  logic [LVLS_W-1:0]   lvl_q;
  logic [NUM_SEGS-1:0] cur_pat;
  logic [SLICE_W-1:0]  cur_lvl;

  led_scan_timer #(
    .NUM_DIGITS(NUM_DIGITS), .SLOT_TICKS(SLOT_TICKS), .CNT_W(CNT_W), .DIG_W(DIG_W)
  ) u_timer (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .tick_en_i(tick_en_i),
    .cnt_o    (cnt),
    .dig_o    (dig),
    .blank_o  (blank),
    .dig_en_o (digit_en_o)
  );

  // Frame data is taken only in the blank clock that opens digit 0.
  assign cfg_ready_o = blank & (dig == '0) & ~rst_i;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      pat_q <= '0;
      lvl_q <= '0;
    end else if (cfg_valid_i && cfg_ready_o) begin
      pat_q <= cfg_pattern_i;
      lvl_q <= cfg_level_i;
    end
  end

  always_comb begin
    cur_pat = '0;
    cur_lvl = '0;
    for (int d = 0; d < NUM_DIGITS; d++) begin
      if (dig == DIG_W'(d)) begin
        cur_pat = pat_q[d*NUM_SEGS +: NUM_SEGS];
        cur_lvl = lvl_q[d*SLICE_W +: SLICE_W];
      end
    end
  end

  led_seg_pwm #(
    .NUM_SEGS(NUM_SEGS), .LVL_W(LVL_W), .LVL_MAX(LVL_MAX),
    .SLOT_TICKS(SLOT_TICKS), .CNT_W(CNT_W)
  ) u_pwm (
    .cnt_i  (cnt),
    .blank_i(blank),
    .pat_i  (cur_pat),
    .lvl_i  (cur_lvl),
    .seg_o  (seg_o)
  );

  AST_LATCH_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    !(cfg_valid_i && cfg_ready_o) |=> ($stable(pat_q) && $stable(lvl_q))); // R7
  AST_DARK_BEFORE_SWITCH: assert property (@(posedge clk_i) disable iff (rst_i)
    (digit_en_o != $past(digit_en_o)) |-> ($past(seg_o) == '0)); // R6
  AST_SEG_MATCHES_DIGIT: assert property (@(posedge clk_i) disable iff (rst_i)
    (seg_o != '0) |-> (digit_en_o == (NUM_DIGITS'(1) << dig))); // R4
endmodule

// File: tb/led_mux_pwm_tb.sv
module led_mux_pwm_tb;
  localparam int TICK_HZ = 6000;
  localparam int FRAME_HZ = 100;
  localparam int ND = 3;
  localparam int NS = 8;
  localparam int LMAX = 6;
  localparam int LW = 3;
  localparam int SLOT = TICK_HZ / (FRAME_HZ * ND);
  localparam int PW = ND * NS;
  localparam int LVW = PW * LW;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic           rst = 1'b1;
  logic           tick_en = 1'b0;
  logic           cfg_valid = 1'b0;
  logic           cfg_ready;
  logic [PW-1:0]  cfg_pat = '0;
  logic [LVW-1:0] cfg_lvl = '0;
  logic [ND-1:0]  digit_en;
  logic [NS-1:0]  seg;

  led_mux_pwm #(
    .TICK_HZ(TICK_HZ), .FRAME_HZ(FRAME_HZ), .NUM_DIGITS(ND), .NUM_SEGS(NS), .LVL_MAX(LMAX)
  ) u_dut (
    .clk_i(clk), .rst_i(rst), .tick_en_i(tick_en), .cfg_valid_i(cfg_valid),
    .cfg_ready_o(cfg_ready), .cfg_pattern_i(cfg_pat), .cfg_level_i(cfg_lvl),
    .digit_en_o(digit_en), .seg_o(seg)
  );

  int tests = 0;
  int fails = 0;

  // reference state
  logic           m_blank = 1'b1;
  int             m_cnt = 0;
  int             m_dig = 0;
  logic [ND-1:0]  m_den = '0;
  logic [PW-1:0]  m_pat = '0;
  logic [LVW-1:0] m_lvl = '0;
  logic           prev_tick = 1'b1;
  bit             counting = 1'b0;
  bit             saw_ready = 1'b0;
  int             hi_cnt [NS];

  function automatic int exp_on(input int lin);
    int l;
    real r;
    int v;
    l = (lin > LMAX) ? LMAX : lin;
    if (l == 0) return 0;
    if (l == LMAX) return SLOT;
    r = real'(l) / real'(LMAX);
    v = $rtoi(real'(SLOT) * $pow(r, 2.2) + 0.5);
    if (v < 1) v = 1;
    return v;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic tk, input logic vl,
                      input logic [PW-1:0] p, input logic [LVW-1:0] lv);
    logic [NS-1:0] eseg;
    logic          erdy;
    @(negedge clk);
    erdy = m_blank && (m_dig == 0) && !rst;
    for (int s = 0; s < NS; s++)
      eseg[s] = !m_blank && m_pat[m_dig*NS+s] && (m_cnt < exp_on(int'(m_lvl[(m_dig*NS+s)*LW +: LW])));
    check(rst ? "R1 seg" : (m_blank ? "R6 seg" : "R4 seg"), 32'(seg), 32'(eseg));
    check(rst ? "R1 digit_en" : (prev_tick ? "R2 digit_en" : "R3 digit_en"), 32'(digit_en), 32'(m_den));
    check(rst ? "R1 ready" : "R7 ready", 32'(cfg_ready), 32'(erdy));
    if (cfg_ready) saw_ready = 1'b1;
    if (counting && digit_en == ND'(1))
      for (int s = 0; s < NS; s++) hi_cnt[s] += int'(seg[s]);
    rst = r; tick_en = tk; cfg_valid = vl; cfg_pat = p; cfg_lvl = lv;
    prev_tick = tk;
    if (r) begin
      m_blank = 1'b1; m_cnt = 0; m_dig = 0; m_den = '0; m_pat = '0; m_lvl = '0;
    end else begin
      if (m_blank && m_dig == 0 && vl) begin
        m_pat = p; m_lvl = lv;
      end
      m_den = ND'(1) << m_dig;
      if (m_blank) m_blank = 1'b0;
      else if (tk) begin
        if (m_cnt == SLOT - 1) begin
          m_cnt = 0; m_blank = 1'b1; m_dig = (m_dig == ND - 1) ? 0 : m_dig + 1;
        end else m_cnt++;
      end
    end
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [PW-1:0]  dpat;
    logic [LVW-1:0] dlvl;
    // R1: reset state
    repeat (3) step(1'b1, 1'b0, 1'b0, '0, '0);
    // mixed sweep: R2/R3/R4/R6/R7, reset pulse in the middle
    for (int i = 0; i < 2400; i++) begin
      logic r, tk, vl;
      r  = (i >= 1300 && i < 1303);
      tk = (i < 600) ? 1'b1 : (($urandom % 4) != 0);
      vl = (i < 5) ? 1'b1 : 1'($urandom % 2);
      step(r, tk, vl, PW'({$urandom, $urandom}), LVW'({$urandom, $urandom, $urandom}));
    end
    // directed R5: segment s at level s (level 7 exceeds LMAX), all pattern bits set
    dpat = '1;
    dlvl = '0;
    for (int d = 0; d < ND; d++)
      for (int s = 0; s < NS; s++)
        dlvl[(d*NS+s)*LW +: LW] = LW'(s);
    repeat (2 * ND * (SLOT + 1) + 4) step(1'b0, 1'b1, 1'b1, dpat, dlvl);
    saw_ready = 1'b0;
    while (!saw_ready) step(1'b0, 1'b1, 1'b1, dpat, dlvl);
    for (int s = 0; s < NS; s++) hi_cnt[s] = 0;
    counting = 1'b1;
    repeat (ND * (SLOT + 1)) step(1'b0, 1'b1, 1'b1, dpat, dlvl);
    counting = 1'b0;
    for (int s = 0; s < NS; s++) check("R5 on-time", 32'(hi_cnt[s]), 32'(exp_on(s)));
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule